// File: doc/BRIEF.md
# Block-Matching Motion Search Engine

This engine takes one 8x8 block of the current frame at a time and searches a window of the previous frame around that block's own position for the displacement whose pixels differ least from it. The measure is the sum of absolute differences (SAD) over the 64 pixel pairs. The block arrives as a stream of 64 pixels in row-major order. An input FIFO absorbs this stream, so the next block can be delivered while the present one is still being searched. The block being searched sits in a shift-register store that writes every word back to its tail as it leaves the head. The same 64 pixels are therefore replayed for each displacement.

Reference pixels live in two external frame banks with one-cycle synchronous read. One bank is the reference, holding the last decoded frame. The other bank is the fill bank and takes a new frame from a sequential writer. Each bank has its own address counter inside the engine. A `frame_done` pulse swaps the two roles and restarts the block position at the top-left of the frame. Blocks are taken in raster order across the frame. Each result is a signed motion vector and its SAD, offered with a valid flag that stays up until the reader acknowledges it.

The controller is a state machine with these states:

- **IDLE**: clears the running minimum and resets the candidate to the first corner.
- **LOAD**: moves 64 words from the input FIFO into the register store.
- **SETUP**: tests whether the candidate is in range. If so, it loads the reference address counter and clears the accumulator.
- **SCAN**: issues 64 reference reads while the register store rotates.
- **DRAIN**: absorbs the last read's latency.
- **CMP**: updates the minimum.
- **PUBLISH**: hands the result out once the previous result has been acknowledged.

The transitions are:

- IDLE goes to LOAD when the FIFO is not empty.
- LOAD goes to SETUP after the 64th word.
- SETUP goes to SCAN for an in-frame candidate. For an off-frame candidate it stays in SETUP on the next candidate, or goes to PUBLISH if that was the last one.
- SCAN goes to DRAIN after 64 reads.
- DRAIN goes to CMP.
- CMP goes to SETUP, or to PUBLISH after the last candidate.
- PUBLISH goes to IDLE when the output is free.

Top module: `motion_search_engine`

## Requirements
- R1: After reset `mv_valid` is 0, `cur_ready` is 1, both bank write enables are 0, bank 0 is the reference bank and the block position is the top-left block.
- R2: The reported `mv_sad` equals the sum over the 64 pixel pairs of |current − reference|. It is the minimum over all in-frame candidates with displacement in [−RANGE, +RANGE] on each axis.
- R3: Candidates are visited with the vertical offset in the outer loop and the horizontal offset in the inner loop, both ascending from −RANGE. A candidate replaces the minimum only with a strictly smaller SAD, so the first-visited candidate wins a tie.
- R4: A candidate whose 8x8 window would leave the frame is never evaluated, so a block on the frame edge never reports a vector pointing outside the frame.
- R5: `mv_valid` holds, and `mv_x`, `mv_y` and `mv_sad` stay unchanged, until `mv_ack` is sampled high. `mv_valid` is then 0 in the following cycle.
- R6: While a result is unacknowledged, a finished search of the next block is held back. It is published in the second cycle after the acknowledge.
- R7: The input FIFO holds one full block, so the 64 pixels of the next block are accepted at one per cycle while a search is running.
- R8: When `ref_sel` is 0, bank 0 is the reference and bank 1 the fill bank, and `frame_done` toggles `ref_sel`. Each `wr_valid` writes `wr_pix` into the fill bank at consecutive addresses starting at 0 after reset or `frame_done`. Address equals y·FRAME_W + x. The reference bank is never written.
- R9: The running minimum restarts at its all-ones value for each block, so a block's result does not depend on earlier blocks.
- R10: `mv_x` and `mv_y` are VW-bit two's-complement values. Positive x points right and positive y points down. The vector names the reference window's top-left corner relative to the current block's top-left corner (for example, −2 is 4'b1110).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_valid | input | 1 | Current-block pixel offered |
| cur_ready | output | 1 | Input FIFO has room |
| cur_pix | input | PIX_W | Current-block pixel, row-major within the block |
| wr_valid | input | 1 | Fill-bank pixel offered (always taken) |
| wr_pix | input | PIX_W | Fill-bank pixel, raster order over the frame |
| frame_done | input | 1 | Swap bank roles and restart the block position |
| bank0_addr | output | AW | Bank 0 address |
| bank0_we | output | 1 | Bank 0 write enable |
| bank0_wdata | output | PIX_W | Bank 0 write data |
| bank0_rdata | input | PIX_W | Bank 0 read data, one cycle after the address |
| bank1_addr | output | AW | Bank 1 address |
| bank1_we | output | 1 | Bank 1 write enable |
| bank1_wdata | output | PIX_W | Bank 1 write data |
| bank1_rdata | input | PIX_W | Bank 1 read data, one cycle after the address |
| mv_valid | output | 1 | Result available |
| mv_ack | input | 1 | Reader has taken the result |
| mv_x | output | VW | Horizontal displacement, two's complement |
| mv_y | output | VW | Vertical displacement, two's complement |
| mv_sad | output | SAD_W | SAD of the chosen displacement |

## Verification
The bench places a constant patch around one block so that every candidate scores zero. A design that replaced the minimum on equality would report (0,0) or the last corner instead of the first in-frame one. Blocks on the left, top and right edges check that off-frame candidates are skipped. An engine that read outside the frame, or wrapped its addresses, would return a vector pointing off the frame or a wrong SAD. A block whose SAD is nonzero follows a block whose SAD was zero. An engine that kept its old minimum would never update and would report a stale vector. The bench holds the acknowledge back during a whole search to catch a result that is overwritten rather than stalled. It fills the spare bank and swaps roles, which catches a swapped bank-select polarity or a write that lands in the reference bank.

// File: rtl/mse_pkg.sv
package mse_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SETUP,
        ST_SCAN,
        ST_DRAIN,
        ST_CMP,
        ST_PUBLISH
    } mse_state_t;

endpackage

// File: rtl/mse_in_fifo.sv
module mse_in_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int PW = $clog2(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PW:0]      wr_q;
    logic [PW:0]      rd_q;

    assign full  = (wr_q[PW] != rd_q[PW]) && (wr_q[PW-1:0] == rd_q[PW-1:0]);
    assign empty = (wr_q == rd_q);
    assign dout  = store[rd_q[PW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (push && !full) wr_q <= wr_q + 1'b1;
            if (pop && !empty) rd_q <= rd_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) store[wr_q[PW-1:0]] <= din;
    end
endmodule

// File: rtl/mse_reg_fifo.sv
module mse_reg_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             shift,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] head
);
    logic [WIDTH-1:0] cells [DEPTH];

    assign head = cells[0];

    for (genvar i = 0; i < DEPTH - 1; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (shift) cells[i] <= cells[i+1];
        end
    end

    // tail takes new data while loading, otherwise the word leaving the head
    always_ff @(posedge clk) begin
        if (shift) cells[DEPTH-1] <= load ? din : cells[0];
    end
endmodule

// File: rtl/mse_sad_acc.sv
module mse_sad_acc #(
    parameter int PIX_W = 8,
    parameter int SAD_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [PIX_W-1:0] cur_px,
    input  logic [PIX_W-1:0] ref_px,
    output logic [SAD_W-1:0] sum
);
    logic [PIX_W-1:0] absdiff;

    assign absdiff = (cur_px >= ref_px) ? (cur_px - ref_px) : (ref_px - cur_px);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sum <= '0;
        else if (clr) sum <= '0;
        else if (en)  sum <= sum + SAD_W'(absdiff);
    end
endmodule

// File: rtl/motion_search_engine.sv
module motion_search_engine
    import mse_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int FRAME_W = 128,
    parameter int FRAME_H = 128,
    parameter int BLK     = 8,
    parameter int RANGE   = 4,
    localparam int AW     = $clog2(FRAME_W * FRAME_H),
    localparam int NPIX   = BLK * BLK,
    localparam int SAD_W  = $clog2(NPIX * ((1 << PIX_W) - 1) + 1),
    localparam int VW     = $clog2(RANGE + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cur_valid,
    output logic                    cur_ready,
    input  logic [PIX_W-1:0]        cur_pix,
    input  logic                    wr_valid,
    input  logic [PIX_W-1:0]        wr_pix,
    input  logic                    frame_done,
    output logic [AW-1:0]           bank0_addr,
    output logic                    bank0_we,
    output logic [PIX_W-1:0]        bank0_wdata,
    input  logic [PIX_W-1:0]        bank0_rdata,
    output logic [AW-1:0]           bank1_addr,
    output logic                    bank1_we,
    output logic [PIX_W-1:0]        bank1_wdata,
    input  logic [PIX_W-1:0]        bank1_rdata,
    output logic                    mv_valid,
    input  logic                    mv_ack,
    output logic signed [VW-1:0]    mv_x,
    output logic signed [VW-1:0]    mv_y,
    output logic [SAD_W-1:0]        mv_sad
);
    localparam int PC_W      = $clog2(NPIX);
    localparam int BCOLS     = FRAME_W / BLK;
    localparam int BROWS     = FRAME_H / BLK;
    localparam int BCW       = (BCOLS > 1) ? $clog2(BCOLS) : 1;
    localparam int BRW       = (BROWS > 1) ? $clog2(BROWS) : 1;
    localparam int FRAME_PIX = FRAME_W * FRAME_H;
    localparam int ROW_JUMP  = FRAME_W - BLK + 1;

    mse_state_t state_q, state_d;

    logic [PC_W-1:0]        pix_q;
    logic signed [VW-1:0]   cdx_q, cdy_q, nx_dx, nx_dy;
    logic [SAD_W-1:0]       min_sad_q;
    logic signed [VW-1:0]   min_x_q, min_y_q;
    logic                   ref_sel;
    logic [BCW-1:0]         bcol_q;
    logic [BRW-1:0]         brow_q;
    logic                   scan_d_q;
    logic [PIX_W-1:0]       cur_d_q;

    logic                   fifo_full, fifo_empty, fifo_pop;
    logic [PIX_W-1:0]       fifo_dout, rf_head, ref_px;
    logic [SAD_W-1:0]       sad_sum;

    int                     cand_x, cand_y, cand_base_i;
    logic                   cand_ok, cand_last, pix_last;
    logic [AW-1:0]          cand_base, addr_step;

    // ---------------- candidate geometry ----------------
    assign cand_x      = int'(bcol_q) * BLK + int'(cdx_q);
    assign cand_y      = int'(brow_q) * BLK + int'(cdy_q);
    assign cand_ok     = (cand_x >= 0) && (cand_x <= FRAME_W - BLK) &&
                         (cand_y >= 0) && (cand_y <= FRAME_H - BLK);
    assign cand_last   = (cdx_q == VW'(RANGE)) && (cdy_q == VW'(RANGE));
    assign cand_base_i = cand_y * FRAME_W + cand_x;
    assign cand_base   = AW'(cand_base_i);
    assign pix_last    = (pix_q == PC_W'(NPIX - 1));
    assign addr_step   = ((int'(pix_q) % BLK) == BLK - 1) ? AW'(ROW_JUMP) : AW'(1);

    always_comb begin
        if (cdx_q == VW'(RANGE)) begin
            nx_dx = VW'(-RANGE);
            nx_dy = cdy_q + VW'(1);
        end else begin
            nx_dx = cdx_q + VW'(1);
            nx_dy = cdy_q;
        end
    end

    // ---------------- submodules ----------------
    assign cur_ready = !fifo_full;
    assign fifo_pop  = (state_q == ST_LOAD) && !fifo_empty;

    mse_in_fifo #(.WIDTH(PIX_W), .DEPTH(NPIX)) u_in_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cur_valid),
        .din   (cur_pix),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    mse_reg_fifo #(.WIDTH(PIX_W), .DEPTH(NPIX)) u_reg_fifo (
        .clk   (clk),
        .shift (fifo_pop || (state_q == ST_SCAN)),
        .load  (state_q == ST_LOAD),
        .din   (fifo_dout),
        .head  (rf_head)
    );

    assign ref_px = ref_sel ? bank1_rdata : bank0_rdata;

    mse_sad_acc #(.PIX_W(PIX_W), .SAD_W(SAD_W)) u_sad (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state_q == ST_SETUP),
        .en     (scan_d_q),
        .cur_px (cur_d_q),
        .ref_px (ref_px),
        .sum    (sad_sum)
    );

    // ---------------- bank address counters ----------------
    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic          is_ref;
        logic [AW-1:0] cnt_q;
        logic          we;

        assign is_ref = (ref_sel == 1'(g));
        assign we     = !is_ref && wr_valid && !frame_done;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (frame_done) begin
                cnt_q <= '0;
            end else if (is_ref) begin
                if (state_q == ST_SETUP && cand_ok) cnt_q <= cand_base;
                else if (state_q == ST_SCAN)        cnt_q <= cnt_q + addr_step;
            end else if (wr_valid) begin
                cnt_q <= (cnt_q == AW'(FRAME_PIX - 1)) ? '0 : cnt_q + 1'b1;
            end
        end
    end

    assign bank0_addr  = g_bank[0].cnt_q;
    assign bank0_we    = g_bank[0].we;
    assign bank0_wdata = wr_pix;
    assign bank1_addr  = g_bank[1].cnt_q;
    assign bank1_we    = g_bank[1].we;
    assign bank1_wdata = wr_pix;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (!fifo_empty)            state_d = ST_LOAD;
            ST_LOAD:    if (fifo_pop && pix_last)   state_d = ST_SETUP;
            ST_SETUP: begin
                if (cand_ok)        state_d = ST_SCAN;
                else if (cand_last) state_d = ST_PUBLISH;
            end
            ST_SCAN:    if (pix_last)               state_d = ST_DRAIN;
            ST_DRAIN:                               state_d = ST_CMP;
            ST_CMP:     state_d = cand_last ? ST_PUBLISH : ST_SETUP;
            ST_PUBLISH: if (!mv_valid)              state_d = ST_IDLE;
            default:                                state_d = ST_IDLE;
        endcase
    end

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q     <= '0;
            cdx_q     <= VW'(-RANGE);
            cdy_q     <= VW'(-RANGE);
            min_sad_q <= '1;
            min_x_q   <= '0;
            min_y_q   <= '0;
            mv_valid  <= 1'b0;
            mv_x      <= '0;
            mv_y      <= '0;
            mv_sad    <= '0;
            ref_sel   <= 1'b0;
            bcol_q    <= '0;
            brow_q    <= '0;
            scan_d_q  <= 1'b0;
            cur_d_q   <= '0;
        end else begin
            scan_d_q <= (state_q == ST_SCAN);
            if (state_q == ST_SCAN) cur_d_q <= rf_head;
            if (mv_ack) mv_valid <= 1'b0;

            unique case (state_q)
                ST_IDLE: begin
                    pix_q     <= '0;
                    cdx_q     <= VW'(-RANGE);
                    cdy_q     <= VW'(-RANGE);
                    min_sad_q <= '1;
                end
                ST_LOAD:  if (fifo_pop) pix_q <= pix_q + 1'b1;
                ST_SETUP: begin
                    pix_q <= '0;
                    if (!cand_ok && !cand_last) begin
                        cdx_q <= nx_dx;
                        cdy_q <= nx_dy;
                    end
                end
                ST_SCAN:  pix_q <= pix_q + 1'b1;
                ST_DRAIN: ;
                ST_CMP: begin
                    if (sad_sum < min_sad_q) begin
                        min_sad_q <= sad_sum;
                        min_x_q   <= cdx_q;
                        min_y_q   <= cdy_q;
                    end
                    if (!cand_last) begin
                        cdx_q <= nx_dx;
                        cdy_q <= nx_dy;
                    end
                end
                ST_PUBLISH: begin
                    if (!mv_valid) begin
                        mv_valid <= 1'b1;
                        mv_x     <= min_x_q;
                        mv_y     <= min_y_q;
                        mv_sad   <= min_sad_q;
                        if (bcol_q == BCW'(BCOLS - 1)) begin
                            bcol_q <= '0;
                            brow_q <= (brow_q == BRW'(BROWS - 1)) ? '0 : brow_q + 1'b1;
                        end else begin
                            bcol_q <= bcol_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase

            if (frame_done) begin
                ref_sel <= !ref_sel;
                bcol_q  <= '0;
                brow_q  <= '0;
            end
        end
    end
endmodule

// File: rtl/mse_chk.sv
module mse_chk #(
    parameter int VW    = 4,
    parameter int SAD_W = 14,
    parameter int RANGE = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mv_valid,
    input logic                 mv_ack,
    input logic signed [VW-1:0] mv_x,
    input logic signed [VW-1:0] mv_y,
    input logic [SAD_W-1:0]     mv_sad,
    input logic                 ref_sel,
    input logic                 frame_done,
    input logic                 bank0_we,
    input logic                 bank1_we
);
    localparam logic signed [VW-1:0] HI = VW'(RANGE);
    localparam logic signed [VW-1:0] LO = VW'(-RANGE);

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid && !mv_ack) |=> (mv_valid && $stable(mv_x) && $stable(mv_y) && $stable(mv_sad)));

    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid && mv_ack) |=> !mv_valid);

    // R4
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mv_valid) |-> ((mv_x >= LO) && (mv_x <= HI) && (mv_y >= LO) && (mv_y <= HI)));

    // R2
    sad_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mv_valid) |-> (mv_sad != '1));

    // R8
    swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (ref_sel != $past(ref_sel)));

    // R8
    fill_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bank0_we, bank1_we}) && (!bank0_we || ref_sel) && (!bank1_we || !ref_sel));
endmodule

bind motion_search_engine mse_chk #(.VW(VW), .SAD_W(SAD_W), .RANGE(RANGE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mv_valid   (mv_valid),
    .mv_ack     (mv_ack),
    .mv_x       (mv_x),
    .mv_y       (mv_y),
    .mv_sad     (mv_sad),
    .ref_sel    (ref_sel),
    .frame_done (frame_done),
    .bank0_we   (bank0_we),
    .bank1_we   (bank1_we)
);

// File: tb/motion_search_engine_tb.sv
module motion_search_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 32;
    localparam int FH = 32;
    localparam int AW = 10;
    localparam int VW = 4;
    localparam int SW = 14;
    localparam int WD_LIMIT = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cur_valid = 1'b0, wr_valid = 1'b0, frame_done = 1'b0, mv_ack = 1'b0;
    logic [7:0] cur_pix = '0, wr_pix = '0;
    logic cur_ready, b0_we, b1_we, mv_valid;
    logic [AW-1:0] b0_addr, b1_addr;
    logic [7:0] b0_wdata, b1_wdata, b0_rdata, b1_rdata;
    logic signed [VW-1:0] mv_x, mv_y;
    logic [SW-1:0] mv_sad;

    logic [7:0] mem0 [FW*FH];
    logic [7:0] mem1 [FW*FH];
    logic [7:0] cblk [64];

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    motion_search_engine #(.PIX_W(8), .FRAME_W(FW), .FRAME_H(FH), .BLK(8), .RANGE(4)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cur_valid(cur_valid), .cur_ready(cur_ready), .cur_pix(cur_pix),
        .wr_valid(wr_valid), .wr_pix(wr_pix), .frame_done(frame_done),
        .bank0_addr(b0_addr), .bank0_we(b0_we), .bank0_wdata(b0_wdata), .bank0_rdata(b0_rdata),
        .bank1_addr(b1_addr), .bank1_we(b1_we), .bank1_wdata(b1_wdata), .bank1_rdata(b1_rdata),
        .mv_valid(mv_valid), .mv_ack(mv_ack), .mv_x(mv_x), .mv_y(mv_y), .mv_sad(mv_sad)
    );

    always @(posedge clk) begin
        if (b0_we) mem0[b0_addr] <= b0_wdata;
        b0_rdata <= mem0[b0_addr];
        if (b1_we) mem1[b1_addr] <= b1_wdata;
        b1_rdata <= mem1[b1_addr];
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WD_LIMIT) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, WD_LIMIT);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    function automatic logic [7:0] pat0(input int x, input int y);
        return 8'((x*x*7 + y*53 + x*y*11 + (x ^ y)*29 + 17) & 255);
    endfunction

    function automatic logic [7:0] pat1(input int x, input int y);
        return 8'((x*19 + y*y*5 + x*y*23 + (x ^ (y*3))*41 + 99) & 255);
    endfunction

    function automatic logic [7:0] rd(input int sel, input int x, input int y);
        return (sel == 0) ? mem0[y*FW + x] : mem1[y*FW + x];
    endfunction

    task automatic grab_block(input int sel, input int ox, input int oy);
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                cblk[r*8+c] = rd(sel, ox+c, oy+r);
    endtask

    // independent full-search model: y outer, x inner, strict less wins
    task automatic model(input int sel, input int bx, input int by,
                         output int ex, output int ey, output int es);
        es = 1 << 30; ex = 0; ey = 0;
        for (int dy = -4; dy <= 4; dy++)
            for (int dx = -4; dx <= 4; dx++) begin
                int px = bx*8 + dx;
                int py = by*8 + dy;
                if (px >= 0 && py >= 0 && px <= FW-8 && py <= FH-8) begin
                    int s = 0;
                    for (int r = 0; r < 8; r++)
                        for (int c = 0; c < 8; c++) begin
                            int d = int'(cblk[r*8+c]) - int'(rd(sel, px+c, py+r));
                            s += (d < 0) ? -d : d;
                        end
                    if (s < es) begin es = s; ex = dx; ey = dy; end
                end
            end
    endtask

    task automatic push_block(output int cyc);
        cyc = 0;
        for (int i = 0; i < 64; i++) begin
            bit ok = 0;
            cur_valid = 1'b1;
            cur_pix = cblk[i];
            while (!ok) begin
                ok = cur_ready;
                @(negedge clk);
                cyc++;
            end
        end
        cur_valid = 1'b0;
    endtask

    task automatic wait_result();
        int n = 0;
        while (!mv_valid && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic do_ack();
        mv_ack = 1'b1;
        @(negedge clk);
        mv_ack = 1'b0;
        check(!mv_valid, "R5", "valid after ack", int'(mv_valid), 0);
    endtask

    task automatic check_result(input string req, input int ex, input int ey, input int es);
        check(mv_valid, req, "result valid", int'(mv_valid), 1);
        check(int'(mv_x) == ex, req, "mv_x", int'(mv_x), ex);
        check(int'(mv_y) == ey, req, "mv_y", int'(mv_y), ey);
        check(int'(mv_sad) == es, req, "mv_sad", int'(mv_sad), es);
    endtask

    task automatic test_reset();
        check(!mv_valid, "R1", "mv_valid", int'(mv_valid), 0);
        check(cur_ready, "R1", "cur_ready", int'(cur_ready), 1);
        check(!b0_we && !b1_we, "R1", "write enables", int'({b0_we, b1_we}), 0);
    endtask

    // block 0 at top-left corner: exact copy of the window at (+3,+2)
    task automatic test_corner();
        int ex, ey, es, cyc;
        grab_block(0, 3, 2);
        model(0, 0, 0, ex, ey, es);
        push_block(cyc);
        wait_result();
        check_result("R2", 3, 2, 0);
        check_result("R4", ex, ey, es);
        do_ack();
    endtask

    // block 1 with a small mismatch; block 2 pushed mid-search
    task automatic test_prefetch_and_negative();
        int ex, ey, es, cyc;
        grab_block(0, 6, 1);
        cblk[5] = cblk[5] ^ 8'h01;
        model(0, 1, 0, ex, ey, es);
        push_block(cyc);
        repeat (100) @(negedge clk);
        check(!mv_valid, "R7", "busy before prefetch", int'(mv_valid), 0);
        for (int i = 0; i < 64; i++) cblk[i] = 8'd50;
        push_block(cyc);
        check(cyc <= 66, "R7", "cycles to accept next block", cyc, 64);
        check(!mv_valid, "R7", "still searching after prefetch", int'(mv_valid), 0);
        wait_result();
        // flatten the window of block 2 before its search starts
        for (int y = 0; y < 12; y++)
            for (int x = 12; x < 28; x++) mem0[y*FW + x] = 8'd50;
        check_result("R10", -2, 1, 1);
        check_result("R2", ex, ey, es);
        check(mv_x[3:0] == 4'b1110, "R10", "mv_x raw bits", int'(mv_x[3:0]), 14);
        do_ack();
    endtask

    // block 2: every in-frame candidate scores zero
    task automatic test_tie();
        wait_result();
        check_result("R3", -4, 0, 0);
        do_ack();
        for (int y = 0; y < FH; y++)
            for (int x = 0; x < FW; x++) mem0[y*FW + x] = pat0(x, y);
    endtask

    // block 3 on right edge, block 4 finishes while result 3 is held
    task automatic test_edge_and_stall();
        int ex, ey, es, cyc;
        logic signed [VW-1:0] hx;
        grab_block(0, 21, 2);
        cblk[10] = cblk[10] ^ 8'h02;
        model(0, 3, 0, ex, ey, es);
        push_block(cyc);
        wait_result();
        check_result("R9", ex, ey, es);
        check_result("R4", -3, 2, 2);
        check(int'(mv_x) <= 0, "R4", "right edge mv_x", int'(mv_x), 0);
        hx = mv_x;
        grab_block(0, 2, 5);
        cblk[20] = cblk[20] ^ 8'h04;
        model(0, 0, 1, ex, ey, es);
        push_block(cyc);
        repeat (7000) @(negedge clk);
        check(mv_valid, "R6", "held result valid", int'(mv_valid), 1);
        check(mv_x == hx && int'(mv_sad) == 2, "R6", "held result unchanged", int'(mv_sad), 2);
        do_ack();
        @(negedge clk);
        check(mv_valid, "R6", "next result right after ack", int'(mv_valid), 1);
        check_result("R6", 2, -3, 4);
        check_result("R9", ex, ey, es);
        do_ack();
    endtask

    task automatic test_bank_swap();
        int ex, ey, es, cyc, mism, w0;
        mism = 0; w0 = 0;
        for (int i = 0; i < FW*FH; i++) begin
            wr_valid = 1'b1;
            wr_pix = pat1(i % FW, i / FW);
            #1;
            if (b0_we) w0++;
            @(negedge clk);
        end
        wr_valid = 1'b0;
        for (int i = 0; i < FW*FH; i++)
            if (mem1[i] != pat1(i % FW, i / FW)) mism++;
        check(mism == 0, "R8", "fill bank contents mismatches", mism, 0);
        check(w0 == 0, "R8", "reference bank writes", w0, 0);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        grab_block(1, 1, 4);
        model(1, 0, 0, ex, ey, es);
        push_block(cyc);
        wait_result();
        check_result("R8", 1, 4, 0);
        check_result("R8", ex, ey, es);
        do_ack();
    endtask

    initial begin
        for (int y = 0; y < FH; y++)
            for (int x = 0; x < FW; x++) begin
                mem0[y*FW + x] = pat0(x, y);
                mem1[y*FW + x] = 8'd0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_corner();
        test_prefetch_and_negative();
        test_tie();
        test_edge_and_stall();
        test_bank_swap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule